// File: doc/BRIEF.md
# Floppy Transfer Wait and Drive Select Port

This block is an 8-bit I/O register placed next to a floppy disk controller. It lets the processor move sector bytes by programmed I/O without a status polling loop. When the processor reads the port, the block stretches the access with a wait signal. The stretch lasts until the controller asks for a data byte or reports that its command has ended.

The byte returned by that read carries the controller's interrupt line, inverted, in its most significant bit. Software can therefore tell a data transfer apart from command completion with a single sign test. Writing the port stores the number of the selected drive and the recording density. The block decodes the stored drive number into one select line per drive.

A processor read is offered as a one-cycle request strobe together with the port address. The wait output rises on the next clock edge if the controller is not ready. It falls on the edge that follows the first cycle in which the controller's data request or interrupt is high. The status byte is captured on that same edge.

Top module: `fdsync_port`

## Requirements
- R1: Only I/O address 0x14 is decoded. A read strobe at any other address raises no wait. A write strobe at any other address leaves the drive select and density outputs unchanged.
- R2: A read of the port taken while both `fdc_drq` and `fdc_intrq` are low drives `cpu_wait` high from the next clock edge. It stays high for as long as both inputs stay low.
- R3: While `cpu_wait` is high, the first cycle in which `fdc_drq` or `fdc_intrq` is high ends the wait. `cpu_wait` is low after the next clock edge.
- R4: The read byte is captured on the edge that ends (or avoids) the wait and then holds. Bit 7 is the inverse of `fdc_intrq` in the capture cycle: 0 means the command has ended, 1 means it is still running. Bits 6..0 read as 0.
- R5: A read taken in a cycle where `fdc_drq` or `fdc_intrq` is already high produces no wait cycle, and the byte is captured on that edge.
- R6: A write to the port stores data bits 1..0 as the drive number (binary 00 = drive 0 through 11 = drive 3). Exactly one bit of `drv_sel` is high, at the index equal to the stored number.
- R7: A write to the port stores data bit 3 as the density: 0 is single density (`dbl_density` low), 1 is double density (`dbl_density` high).
- R8: Write data bits 2 and 7..4 have no effect on any output.
- R9: After reset, `drv_sel` is 0001 (drive 0), `dbl_density` is 0, `cpu_wait` is 0, and `io_rdata` is 0x80.
- R10: Asserting reset while a wait is pending drops `cpu_wait` at once, and the aborted read does not resume after reset.
- R11: A further read strobe while a wait is pending neither restarts nor lengthens the wait.
- R12: A write to the port while a wait is pending updates the drive and density outputs and leaves the wait unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_rd | input | 1 | One-cycle I/O read request |
| io_wr | input | 1 | One-cycle I/O write request |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Captured status byte |
| cpu_wait | output | 1 | Wait request to the processor, active high |
| fdc_drq | input | 1 | Controller data request, active high |
| fdc_intrq | input | 1 | Controller command-end interrupt, active high |
| drv_sel | output | 4 | One-hot drive select, active high |
| dbl_density | output | 1 | Density control, 1 = double |

## Verification
The wait release and the select latch are independent, so they can act on the same edge. This happens when a port write lands in the cycle where the controller becomes ready. The bench provokes it by issuing a write to the port in the exact cycle it raises the data request of a pending read. It then checks that the new drive and density appear, that the wait falls, and that the status byte reflects the interrupt line of that cycle. A second overlap is a fresh read strobe while a wait is pending: the bench judges that one by counting the wait cycles against the delay it chose.

// File: rtl/fdsync_pkg.sv
package fdsync_pkg;

    // Read-wait sequencer states
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HOLD = 1'b1
    } wait_st_e;

    localparam int unsigned FDS_ADDR_W   = 8;
    localparam int unsigned FDS_DATA_W   = 8;
    localparam int unsigned FDS_NUM_DRV  = 4;
    localparam int unsigned FDS_DENS_BIT = 3;
    localparam int unsigned FDS_STAT_BIT = 7;

endpackage

// File: rtl/fdsync_decode.sv
module fdsync_decode #(
    parameter int unsigned                  ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]            PORT_ADDR = 8'h14
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              rd_hit,
    output logic              wr_hit
);

    logic sel_match;

    always_comb begin
        sel_match = (io_addr == PORT_ADDR);
        rd_hit    = io_rd && sel_match;
        wr_hit    = io_wr && sel_match;
    end

endmodule

// File: rtl/fdsync_waitctl.sv
module fdsync_waitctl
    import fdsync_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned STAT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic              fdc_drq,
    input  logic              fdc_intrq,
    output logic              cpu_wait,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] STAT_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << STAT_BIT;
    localparam logic [DATA_W-1:0] RDATA_RST = STAT_MASK;

    typedef struct packed {
        wait_st_e          st;
        logic [DATA_W-1:0] rdata;
    } wstate_t;

    wstate_t            s_d, s_q;
    logic               ready;
    logic [DATA_W-1:0]  status_w;

    always_comb begin
        ready              = fdc_drq || fdc_intrq;
        status_w           = '0;
        status_w[STAT_BIT] = ~fdc_intrq;

        s_d = s_q;
        unique case (s_q.st)
            WS_IDLE: begin
                if (rd_hit) begin
                    if (ready) s_d.rdata = status_w;
                    else       s_d.st    = WS_HOLD;
                end
            end
            WS_HOLD: begin
                if (ready) begin
                    s_d.st    = WS_IDLE;
                    s_d.rdata = status_w;
                end
            end
            default: s_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= WS_IDLE;
            s_q.rdata <= RDATA_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_wait = (s_q.st == WS_HOLD);
    assign rdata    = s_q.rdata;

    // R2: an unready read starts a wait
    p_wait_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !cpu_wait && !fdc_drq && !fdc_intrq) |=> cpu_wait);

    // R2: the wait holds while the controller is idle
    p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && !fdc_drq && !fdc_intrq) |=> cpu_wait);

    // R3: readiness releases the wait on the next edge
    p_wait_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wait && (fdc_drq || fdc_intrq)) |=> !cpu_wait);

    // R5: a read with the controller already ready never waits
    p_no_wait_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !cpu_wait && (fdc_drq || fdc_intrq)) |=> !cpu_wait);

    // R4: captured status byte reflects the interrupt line
    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fdc_drq || fdc_intrq) && (rd_hit || cpu_wait)) |=>
        ((rdata[STAT_BIT] == !$past(fdc_intrq)) && ((rdata & ~STAT_MASK) == '0)));

    // R4: the byte holds between captures
    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!((fdc_drq || fdc_intrq) && (rd_hit || cpu_wait))) |=> $stable(rdata));

    // R1: no wait can arise without a decoded read
    p_wait_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wait && !rd_hit) |=> !cpu_wait);

endmodule

// File: rtl/fdsync_sel.sv
module fdsync_sel #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_DRV  = 4,
    parameter int unsigned DENS_BIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_DRV-1:0] drv_sel,
    output logic               dbl_density
);

    localparam int unsigned SEL_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;

    typedef struct packed {
        logic [SEL_W-1:0] drv;
        logic             dens;
    } sstate_t;

    sstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hit) begin
            s_d.drv  = wdata[SEL_W-1:0];
            s_d.dens = wdata[DENS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.drv  <= '0;
            s_q.dens <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        assign drv_sel[g] = (s_q.drv == SEL_W'(g));
    end

    assign dbl_density = s_q.dens;

    // R6: exactly one drive is selected
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv_sel) == 1);

    // R6: a port write picks the drive from the low data bits
    p_drive_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (drv_sel == (NUM_DRV'(1) << $past(wdata[SEL_W-1:0]))));

    // R7: a port write picks the density from its bit
    p_dens_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (dbl_density == $past(wdata[DENS_BIT])));

    // R1: without a decoded write the outputs stay put
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(drv_sel) && $stable(dbl_density)));

endmodule

// File: rtl/fdsync_port.sv
module fdsync_port
    import fdsync_pkg::*;
#(
    parameter int unsigned             ADDR_W    = FDS_ADDR_W,
    parameter int unsigned             DATA_W    = FDS_DATA_W,
    parameter int unsigned             NUM_DRV   = FDS_NUM_DRV,
    parameter int unsigned             DENS_BIT  = FDS_DENS_BIT,
    parameter int unsigned             STAT_BIT  = FDS_STAT_BIT,
    parameter logic [ADDR_W-1:0]       PORT_ADDR = 8'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    output logic               cpu_wait,
    input  logic               fdc_drq,
    input  logic               fdc_intrq,
    output logic [NUM_DRV-1:0] drv_sel,
    output logic               dbl_density
);

    logic rd_hit;
    logic wr_hit;

    fdsync_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit)
    );

    fdsync_waitctl #(
        .DATA_W   (DATA_W),
        .STAT_BIT (STAT_BIT)
    ) u_waitctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit    (rd_hit),
        .fdc_drq   (fdc_drq),
        .fdc_intrq (fdc_intrq),
        .cpu_wait  (cpu_wait),
        .rdata     (io_rdata)
    );

    fdsync_sel #(
        .DATA_W   (DATA_W),
        .NUM_DRV  (NUM_DRV),
        .DENS_BIT (DENS_BIT)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .wdata       (io_wdata),
        .drv_sel     (drv_sel),
        .dbl_density (dbl_density)
    );

    // R12: a write never disturbs an idle wait path
    p_wr_no_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !rd_hit && !cpu_wait) |=> !cpu_wait);

endmodule

// File: tb/test_fdsync_port.sv
module test_fdsync_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cpu_wait;
    logic       fdc_drq = 1'b0;
    logic       fdc_intrq = 1'b0;
    logic [3:0] drv_sel;
    logic       dbl_density;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [1:0] m_drv  = 2'd0;
    logic       m_dens = 1'b0;

    always #2.5 clk = ~clk;

    fdsync_port i_fdsync_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .cpu_wait    (cpu_wait),
        .fdc_drq     (fdc_drq),
        .fdc_intrq   (fdc_intrq),
        .drv_sel     (drv_sel),
        .dbl_density (dbl_density)
    );

    function automatic logic [3:0] f_onehot(input logic [1:0] n);
        return 4'b0001 << n;
    endfunction

    function automatic logic [7:0] f_status(input logic intrq);
        return {~intrq, 7'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_sel(input string req);
        chk(req, {28'd0, drv_sel}, {28'd0, f_onehot(m_drv)});
        chk(req, {31'd0, dbl_density}, {31'd0, m_dens});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 8'h14) begin
            m_drv  = d[1:0];
            m_dens = d[3];
        end
        chk_sel(req);
    endtask

    // Read with the controller becoming ready after 'dly' wait cycles.
    // use_int selects which line ends it; restrobe re-issues a read in the first wait cycle;
    // mid_wr writes the port in the cycle readiness arrives.
    task automatic do_read(input int dly, input bit use_int, input bit both,
                           input bit restrobe, input bit mid_wr, input logic [7:0] wd);
        logic intrq_v;
        intrq_v = use_int || both;
        @(negedge clk);
        io_rd = 1'b1; io_addr = 8'h14;
        if (dly == 0) begin
            fdc_drq = !use_int || both; fdc_intrq = intrq_v;
        end
        @(negedge clk);
        io_rd = 1'b0;
        for (int k = 0; k < dly; k++) begin
            chk("R2 wait held", {31'd0, cpu_wait}, 32'd1);
            if (k == 0 && restrobe) io_rd = 1'b1;
            if (k == dly - 1) begin
                fdc_drq = !use_int || both; fdc_intrq = intrq_v;
                if (mid_wr) begin io_wr = 1'b1; io_wdata = wd; end
            end
            @(negedge clk);
            io_rd = 1'b0;
            io_wr = 1'b0;
        end
        if (mid_wr) begin m_drv = wd[1:0]; m_dens = wd[3]; chk_sel("R12 write in wait"); end
        chk(dly == 0 ? "R5 no wait" : "R3 released", {31'd0, cpu_wait}, 32'd0);
        chk("R4 status byte", {24'd0, io_rdata}, {24'd0, f_status(intrq_v)});
        fdc_drq = 1'b0; fdc_intrq = 1'b0;
        @(negedge clk);
        chk("R4 status held", {24'd0, io_rdata}, {24'd0, f_status(intrq_v)});
        chk("R11 no rewait", {31'd0, cpu_wait}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 drv_sel", {28'd0, drv_sel}, 32'h1);
        chk("R9 density", {31'd0, dbl_density}, 32'd0);
        chk("R9 wait", {31'd0, cpu_wait}, 32'd0);
        chk("R9 rdata", {24'd0, io_rdata}, 32'h80);
        rst_n = 1'b1;
        @(negedge clk);

        // R6/R7 directed drive and density
        for (int i = 0; i < 4; i++) do_write(8'h14, 8'(i) | 8'h08, "R6 R7 select");
        do_write(8'h14, 8'h02, "R7 single");
        // R8 ignored bits
        do_write(8'h14, 8'hF5, "R8 ignored bits");
        // R1 other address
        do_write(8'h15, 8'h0B, "R1 other wr addr");
        @(negedge clk);
        io_rd = 1'b1; io_addr = 8'h04;
        @(negedge clk);
        io_rd = 1'b0;
        chk("R1 other rd addr", {31'd0, cpu_wait}, 32'd0);

        // directed reads
        do_read(0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);  // R5 drq already high
        do_read(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);  // R5 intrq already high
        do_read(3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);  // R2 R3 via drq
        do_read(1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);  // R3 via intrq
        do_read(2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);  // R4 both lines
        do_read(4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);  // R11 restrobe in wait
        do_read(3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0E);  // R12 write on release edge

        // R12 write early in a wait leaves it pending
        @(negedge clk);
        io_rd = 1'b1; io_addr = 8'h14;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b1; io_wdata = 8'h09;
        @(negedge clk);
        io_wr = 1'b0; m_drv = 2'd1; m_dens = 1'b1;
        chk_sel("R12 write in wait");
        chk("R12 wait kept", {31'd0, cpu_wait}, 32'd1);

        // R10 reset aborts the wait
        #1 rst_n = 1'b0;
        #1 chk("R10 abort", {31'd0, cpu_wait}, 32'd0);
        m_drv = 2'd0; m_dens = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 no resume", {31'd0, cpu_wait}, 32'd0);
        chk_sel("R9 after reset");

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int unsigned op;
            op = $urandom_range(0, 2);
            if (op == 0) begin
                do_write(($urandom_range(0, 1) == 1) ? 8'h14 : 8'($urandom_range(0, 255)),
                         8'($urandom_range(0, 255)), "R6 R7 R8 random write");
            end else begin
                do_read($urandom_range(0, 6), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)), 1'b0, 8'h00);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule